// File: doc/BRIEF.md
# Block Register-Transfer Address Sequencer

This block takes one block load/store instruction word and the current contents of its base register. It turns the 16-bit register list into an ordered burst of word transfers. It issues one transfer per accepted clock. Each transfer carries the register index, the word address and the direction flag. A ready input from the memory side stalls the burst whenever it is low.

The block supports four address modes: ascending with adjustment after each access, ascending with adjustment before, descending after and descending before. In every mode the selected registers are issued in ascending index order, and the lowest index always lands at the lowest address. When the burst ends, the block raises a one-cycle completion pulse. With that pulse it presents the updated base value and tells whether that value is to be written back.

The privilege flag in the word is not interpreted. It is only carried out alongside the transfers.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset, `busy`, `xferValid`, `done` and `wbValid` are all low.
- R2: Each register selected in the list (bit i of instruction bits 15:0 set means register i) gets exactly one accepted transfer. Transfers are issued in ascending register index.
- R3: With bit 24 = 0 and bit 23 = 1 (ascending, adjust after), the first address is the base. Each following transfer is 4 higher.
- R4: With bit 24 = 1 and bit 23 = 1 (ascending, adjust before), the first address is base + 4. Each following transfer is 4 higher.
- R5: With bit 24 = 0 and bit 23 = 0 (descending, adjust after), the first address is base − 4·n + 4, where n is the number of selected registers. Each following transfer is 4 higher.
- R6: With bit 24 = 1 and bit 23 = 0 (descending, adjust before), the first address is base − 4·n. Each following transfer is 4 higher. Address arithmetic wraps modulo 2^32.
- R7: While `xferValid` is high and `memReady` is low, the register index, the address and the load flag are held. The burst advances only on a cycle with `memReady` high.
- R8: `done` is high for exactly one cycle, the cycle after the last transfer is accepted. With bit 21 = 1, `wbValid` is high in that cycle and `wbValue` is base + 4·n (bit 23 = 1) or base − 4·n (bit 23 = 0).
- R9: With bit 21 = 0, `wbValid` stays low and `wbValue` equals the base in the `done` cycle.
- R10: An empty register list issues no transfer. `done` rises in the second cycle after the start edge, with `wbValid` low and `wbValue` equal to the base.
- R11: `xferLoad` equals bit 20 (1 = load). `xferUser` equals bit 22. `baseSel` equals bits 19:16. A `start` raised while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence; sampled only when idle |
| instrWord | input | 32 | Block transfer instruction word |
| baseValue | input | 32 | Current contents of the base register |
| memReady | input | 1 | Memory side accepts the offered transfer |
| busy | output | 1 | A sequence is in progress |
| xferValid | output | 1 | A transfer is offered |
| xferReg | output | 4 | Register index of the offered transfer |
| xferAddr | output | 32 | Word address of the offered transfer |
| xferLoad | output | 1 | 1 = load, 0 = store |
| xferUser | output | 1 | Privilege flag passed through |
| baseSel | output | 4 | Base register index from the word |
| done | output | 1 | One-cycle completion pulse |
| wbValid | output | 1 | Base writeback requested |
| wbValue | output | 32 | Updated (or unchanged) base value |

## Verification
The bench builds the block with its default parameters: a 16-entry list, 32-bit addresses and a 4-byte word. With these values, the full 16-register list, a single top register and a descending burst that wraps below address zero can all be reached. A list of all ones exercises the widest population count the counter must hold. Alternating ready patterns check that the held outputs survive stalls in the middle of a burst.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_XFER, ST_FINISH} seqState_t;

  typedef struct packed {
    logic load;   // capture word and base
    logic setup;  // capture count and first address
    logic step;   // one transfer accepted
  } seqStrobe_t;
endpackage

// File: rtl/blkxfer_ctrl.sv
module blkxfer_ctrl
  import blkxfer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       memReady,
  input  logic       listEmpty,
  input  logic       lastBeat,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       xferValid,
  output logic       done
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (start) stateNext = ST_SETUP;
      ST_SETUP:  stateNext = listEmpty ? ST_FINISH : ST_XFER;
      ST_XFER:   if (memReady && lastBeat) stateNext = ST_FINISH;
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    strobe.load  = (state == ST_IDLE) && start;
    strobe.setup = (state == ST_SETUP);
    strobe.step  = (state == ST_XFER) && memReady;
  end

  assign busy      = (state != ST_IDLE);
  assign xferValid = (state == ST_XFER);
  assign done      = (state == ST_FINISH);
endmodule

// File: rtl/blkxfer_dpath.sv
module blkxfer_dpath
  import blkxfer_pkg::*;
#(
  parameter int LIST_W     = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  seqStrobe_t                strobe,
  input  logic [31:0]               instrWord,
  input  logic [ADDR_W-1:0]         baseValue,
  output logic                      listEmpty,
  output logic                      lastBeat,
  output logic [$clog2(LIST_W)-1:0] xferReg,
  output logic [ADDR_W-1:0]         xferAddr,
  output logic                      xferLoad,
  output logic                      xferUser,
  output logic [3:0]                baseSel,
  output logic [ADDR_W-1:0]         wbValue,
  output logic                      wbWrite
);
  localparam int IDX_W = $clog2(LIST_W);
  localparam int CNT_W = $clog2(LIST_W + 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [LIST_W-1:0] remMask;
  logic [ADDR_W-1:0] baseReg;
  logic [CNT_W-1:0]  cntReg;
  logic              preFlag, upFlag, wbFlag;

  // population count of the remaining list, unrolled per bit
  logic [CNT_W-1:0] partCnt [LIST_W+1];
  assign partCnt[0] = '0;
  for (genvar i = 0; i < LIST_W; i++) begin : g_pop
    assign partCnt[i+1] = partCnt[i] + CNT_W'(remMask[i]);
  end

  logic [ADDR_W-1:0] spanNow, spanReg, firstAddr;
  assign spanNow = ADDR_W'(partCnt[LIST_W]) * STEP;
  assign spanReg = ADDR_W'(cntReg) * STEP;

  always_comb begin
    unique case ({preFlag, upFlag})
      2'b01:   firstAddr = baseReg;
      2'b11:   firstAddr = baseReg + STEP;
      2'b00:   firstAddr = baseReg - spanNow + STEP;
      default: firstAddr = baseReg - spanNow;
    endcase
  end

  // lowest selected register
  logic [LIST_W-1:0] lowHot;
  assign lowHot = remMask & (~remMask + LIST_W'(1));

  always_comb begin
    xferReg = '0;
    for (int i = LIST_W - 1; i >= 0; i--) begin
      if (remMask[i]) xferReg = IDX_W'(i);
    end
  end

  assign listEmpty = (remMask == '0);
  assign lastBeat  = ((remMask & (remMask - LIST_W'(1))) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remMask  <= '0;
      baseReg  <= '0;
      cntReg   <= '0;
      xferAddr <= '0;
      preFlag  <= 1'b0;
      upFlag   <= 1'b0;
      wbFlag   <= 1'b0;
      xferLoad <= 1'b0;
      xferUser <= 1'b0;
      baseSel  <= '0;
    end else begin
      if (strobe.load) begin
        remMask  <= instrWord[LIST_W-1:0];
        baseReg  <= baseValue;
        preFlag  <= instrWord[24];
        upFlag   <= instrWord[23];
        xferUser <= instrWord[22];
        wbFlag   <= instrWord[21];
        xferLoad <= instrWord[20];
        baseSel  <= instrWord[19:16];
      end
      if (strobe.setup) begin
        cntReg   <= partCnt[LIST_W];
        xferAddr <= firstAddr;
      end
      if (strobe.step) begin
        remMask  <= remMask & ~lowHot;
        xferAddr <= xferAddr + STEP;
      end
    end
  end

  assign wbWrite = wbFlag && (cntReg != '0);
  assign wbValue = !wbFlag ? baseReg : (upFlag ? baseReg + spanReg : baseReg - spanReg);
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int LIST_W     = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [31:0]               instrWord,
  input  logic [ADDR_W-1:0]         baseValue,
  input  logic                      memReady,
  output logic                      busy,
  output logic                      xferValid,
  output logic [$clog2(LIST_W)-1:0] xferReg,
  output logic [ADDR_W-1:0]         xferAddr,
  output logic                      xferLoad,
  output logic                      xferUser,
  output logic [3:0]                baseSel,
  output logic                      done,
  output logic                      wbValid,
  output logic [ADDR_W-1:0]         wbValue
);
  seqStrobe_t strobe;
  logic listEmpty, lastBeat, wbWrite;

  blkxfer_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .memReady(memReady),
    .listEmpty(listEmpty), .lastBeat(lastBeat), .strobe(strobe),
    .busy(busy), .xferValid(xferValid), .done(done)
  );

  blkxfer_dpath #(.LIST_W(LIST_W), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .instrWord(instrWord),
    .baseValue(baseValue), .listEmpty(listEmpty), .lastBeat(lastBeat),
    .xferReg(xferReg), .xferAddr(xferAddr), .xferLoad(xferLoad),
    .xferUser(xferUser), .baseSel(baseSel), .wbValue(wbValue), .wbWrite(wbWrite)
  );

  assign wbValid = done && wbWrite;
endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk #(
  parameter int LIST_W     = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start,
  input logic                      memReady,
  input logic                      busy,
  input logic                      xferValid,
  input logic [$clog2(LIST_W)-1:0] xferReg,
  input logic [ADDR_W-1:0]         xferAddr,
  input logic                      xferLoad,
  input logic                      done,
  input logic                      wbValid
);
  // R7
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xferValid && !memReady) |=> (xferValid && $stable(xferReg) && $stable(xferAddr) && $stable(xferLoad)));

  // R2
  ascending_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xferValid && memReady) |=> (!xferValid || (xferReg > $past(xferReg))));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xferValid && memReady) |=> (!xferValid || (xferAddr == $past(xferAddr) + ADDR_W'(WORD_BYTES))));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> done);

  // R11
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

bind blkxfer_seq blkxfer_seq_chk #(.LIST_W(LIST_W), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .memReady(memReady), .busy(busy),
  .xferValid(xferValid), .xferReg(xferReg), .xferAddr(xferAddr), .xferLoad(xferLoad),
  .done(done), .wbValid(wbValid)
);

// File: tb/sim_blkxfer_seq.sv
`timescale 1ns/1ps
module sim_blkxfer_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] baseValue = '0;
  logic memReady = 1'b0;
  logic busy, xferValid, xferLoad, xferUser, done, wbValid;
  logic [3:0] xferReg, baseSel;
  logic [31:0] xferAddr, wbValue;

  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  blkxfer_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .instrWord(instrWord),
    .baseValue(baseValue), .memReady(memReady), .busy(busy),
    .xferValid(xferValid), .xferReg(xferReg), .xferAddr(xferAddr),
    .xferLoad(xferLoad), .xferUser(xferUser), .baseSel(baseSel),
    .done(done), .wbValid(wbValid), .wbValue(wbValue)
  );

  // {instr, base, expected first address, expected wbValue, expected wbValid}
  localparam logic [128:0] VEC [7] = '{
    {32'hE8BD03AF, 32'h00001000, 32'h00001000, 32'h00001020, 1'b1}, // R3 ascending after
    {32'hE9808001, 32'h00002000, 32'h00002004, 32'h00002000, 1'b0}, // R4 ascending before, R9
    {32'hE87500F0, 32'h00003000, 32'h00002FF4, 32'h00002FF0, 1'b1}, // R5 descending after
    {32'hE92D03AF, 32'h00004000, 32'h00003FE0, 32'h00003FE0, 1'b1}, // R6 descending before
    {32'hE8A1FFFF, 32'h00000100, 32'h00000100, 32'h00000140, 1'b1}, // R2 full list
    {32'hE9320007, 32'h00000004, 32'hFFFFFFF8, 32'hFFFFFFF8, 1'b1}, // R6 wraparound
    {32'hE8338000, 32'h00000500, 32'h00000500, 32'h000004FC, 1'b1}  // R5 single top register
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int popOf(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(m[i]);
    return c;
  endfunction

  function automatic logic [3:0] nthReg(input logic [15:0] m, input int k);
    int seen = 0;
    logic [3:0] r = '0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        if (seen == k) r = 4'(i);
        seen++;
      end
    end
    return r;
  endfunction

  task automatic runSeq(input logic [31:0] instr, input logic [31:0] base,
                        input logic [31:0] first, input logic [31:0] wbExp,
                        input bit wbvExp, input bit stall, input bit poke);
    int beats = 0;
    int n = popOf(instr[15:0]);
    bit seenDone = 0;
    bit tgl = 0;
    @(negedge clk);
    instrWord = instr; baseValue = base; start = 1'b1; memReady = 1'b0;
    for (int cyc = 0; cyc < 200 && !seenDone; cyc++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && busy && !done) begin
        start = 1'b1; instrWord = 32'hE8A0FFFF; baseValue = 32'h999; // R11 ignored while busy
      end
      tgl = ~tgl;
      memReady = stall ? tgl : 1'b1;
      if (xferValid) begin
        chk(xferReg == nthReg(instr[15:0], beats), "R2 register order", 32'(xferReg), 32'(nthReg(instr[15:0], beats)));
        chk(xferAddr == first + 32'(4 * beats), "R3/R4/R5/R6 address", xferAddr, first + 32'(4 * beats));
        chk(xferLoad == instr[20] && xferUser == instr[22] && baseSel == instr[19:16],
            "R11 flags", {26'd0, xferLoad, xferUser, baseSel}, {26'd0, instr[20], instr[22], instr[19:16]});
        if (memReady) beats++;
      end
      if (done) begin
        seenDone = 1;
        start = 1'b0;
        chk(beats == n, "R2 beat count", 32'(beats), 32'(n));
        chk(wbValue == wbExp, "R8/R9 wbValue", wbValue, wbExp);
        chk(wbValid == wbvExp, "R8/R9 wbValid", 32'(wbValid), 32'(wbvExp));
      end
    end
    chk(seenDone, "R8 done seen", 32'(seenDone), 32'd1);
    @(negedge clk);
    memReady = 1'b0;
    chk(!done && !busy, "R8 done one cycle", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !xferValid && !done && !wbValid, "R1 reset state",
        {28'd0, busy, xferValid, done, wbValid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !xferValid && !done && !wbValid, "R1 after release",
        {28'd0, busy, xferValid, done, wbValid}, 32'd0);

    for (int v = 0; v < 7; v++) begin
      runSeq(VEC[v][128:97], VEC[v][96:65], VEC[v][64:33], VEC[v][32:1], VEC[v][0], (v % 2) == 1, 1'b0);
    end

    // R7 stalls plus R11 start ignored while busy
    runSeq(32'hE8A00003, 32'h10, 32'h10, 32'h18, 1'b1, 1'b1, 1'b1);

    // R10 empty list
    @(negedge clk);
    instrWord = 32'hE8A50000; baseValue = 32'h777; start = 1'b1; memReady = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done && !xferValid, "R10 setup cycle", {29'd0, busy, done, xferValid}, 32'd4);
    @(negedge clk);
    chk(done && !xferValid && !wbValid, "R10 done without transfers", {29'd0, done, xferValid, wbValid}, 32'd4);
    chk(wbValue == 32'h777, "R10 base unchanged", wbValue, 32'h777);
    @(negedge clk);
    chk(!done && !busy, "R10 back to idle", {30'd0, done, busy}, 32'd0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule